// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a synchronous host port and a 1M x 16 extended-data-out DRAM. A host request carries a 20-bit word address, a write flag, two byte enables and 16 bits of write data. The controller splits the address into a row and a column and presents them one after the other on a shared 10-bit address bus. It also sequences the row strobe, the two column strobes (one per byte lane), the write strobe and the output enable. Each interval is a whole number of clock cycles, and one down-counter times all of them.

After an access the row stays open. A later request to the same row is served as a page cycle: only the column strobe toggles and a new column is presented. The page is closed before anything else proceeds in three cases: a request to another row, a refresh request from the external refresh arbiter, or the row-open guard nearing its limit. Reads are captured while the column strobe is back high, which relies on the extended data-out hold. The data is returned with a one-cycle valid pulse, in request order.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and right after reset, the row and both column strobes are high, the write strobe and output enable are high, the data bus is not driven, `rd_valid` and `ref_gnt` are low, and `req_ready` is high.
- R2: Request address bits 19:10 appear on `dram_addr` when the row strobe falls, and bits 9:0 appear when a column strobe falls.
- R3: `req_be[0]` selects the lower column strobe and data bits 7:0, and `req_be[1]` selects the upper column strobe and data bits 15:8. A word access asserts both strobes. A write changes only the enabled lanes.
- R4: For a write, the write strobe is low and the write data is driven at least one cycle before any column strobe falls, and the output enable stays high.
- R5: A request to the row that is currently open produces a column cycle with no new row-strobe fall.
- R6: Each time the row strobe falls, it has been high for at least `T_RP` cycles.
- R7: Read data is sampled at the end of the column-precharge interval and returned with a `rd_valid` pulse exactly one cycle wide.
- R8: A refresh request closes an open page. `ref_gnt` is high only while the row strobe and both column strobes are high, and `req_ready` is low while the grant is held.
- R9: The row strobe never stays low for more than `RAS_LIMIT` consecutive cycles. An idle open row is closed on its own.
- R10: A column strobe falls `T_RCD`+1 cycles after the row strobe falls, stays low for exactly `T_CAS` cycles, and is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| ref_req | input | 1 | Refresh arbiter asks for the DRAM |
| ref_gnt | output | 1 | DRAM idle and precharged, handed to the refresh arbiter |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
A stale open-row register shows up at the pins within one request: a page hit that should reuse the row brings an extra row-strobe fall, or a row miss gets no fall at all. The second case returns data from the wrong row on the very next read. A wrong timer load appears in the first cycle of the affected interval as a column pulse or row-to-column delay of the wrong length. A guard counter that fails to clear or expire shows up as a row strobe held low past its limit within `RAS_LIMIT` cycles of idling. A state machine that leaves its write or read phase at the wrong edge corrupts a byte lane or a returned word at once.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_COL, ST_CAS, ST_CP, ST_OPEN, ST_PRE, ST_REF
  } edo_state_e;
endpackage

// File: rtl/edo_interval_timer.sv
module edo_interval_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
  assign zero = (cnt == '0);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int LIMIT = 12500,
  parameter int GUARD = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic row_low,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CAP  = CW'(LIMIT);
  localparam logic [CW-1:0] TRIP = CW'(LIMIT - GUARD);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || !row_low) cnt <= '0;
    else if (cnt != CAP) cnt <= cnt + 1'b1;
  end
  assign expired = (cnt >= TRIP);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int LANE_W    = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 2,
  parameter int T_RP      = 3,
  parameter int RAS_LIMIT = 12500
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ROW_W+COL_W-1:0]    req_addr,
  input  logic                      req_write,
  input  logic [1:0]                req_be,
  input  logic [2*LANE_W-1:0]       req_wdata,
  output logic                      rd_valid,
  output logic [2*LANE_W-1:0]       rd_data,
  input  logic                      ref_req,
  output logic                      ref_gnt,
  output logic                      dram_ras_n,
  output logic                      dram_ucas_n,
  output logic                      dram_lcas_n,
  output logic                      dram_we_n,
  output logic                      dram_oe_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [2*LANE_W-1:0]       dram_dq_out,
  output logic                      dram_dq_oe,
  input  logic [2*LANE_W-1:0]       dram_dq_in
);
  import edo_pkg::*;

  localparam int DATA_W = 2 * LANE_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX_B = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int GUARD  = T_CAS + T_CP + 3;

  edo_state_e st, st_n;
  logic          tmr_load, tmr_zero, ras_exp;
  logic [TW-1:0] tmr_val;

  logic [ROW_W-1:0]  hold_row, open_row;
  logic [COL_W-1:0]  hold_col;
  logic              hold_wr, pend;
  logic [1:0]        hold_be, cas_n;
  logic [DATA_W-1:0] hold_wd;

  logic              accept, row_hit;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_wd;

  assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN && !ras_exp)) && !ref_req;
  assign accept    = req_valid && req_ready;
  assign row_hit   = (req_addr[ROW_W+COL_W-1:COL_W] == open_row);
  assign cur_row   = accept ? req_addr[ROW_W+COL_W-1:COL_W] : hold_row;
  assign cur_col   = accept ? req_addr[COL_W-1:0] : hold_col;
  assign cur_wr    = accept ? req_write : hold_wr;
  assign cur_wd    = accept ? req_wdata : hold_wd;

  edo_interval_timer #(.W(TW)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .value(tmr_val), .zero(tmr_zero)
  );

  edo_ras_guard #(.LIMIT(RAS_LIMIT), .GUARD(GUARD)) guard_i (
    .clk(clk), .rst(rst), .row_low(!dram_ras_n), .expired(ras_exp)
  );

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: begin
        if (ref_req) st_n = ST_REF;
        else if (req_valid) begin
          st_n = ST_ACT; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
        end
      end
      ST_ACT: if (tmr_zero) st_n = ST_COL;
      ST_COL: begin
        st_n = ST_CAS; tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      ST_CAS: if (tmr_zero) begin
        st_n = ST_CP; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
      end
      ST_CP: if (tmr_zero) st_n = ST_OPEN;
      ST_OPEN: begin
        if (ref_req || ras_exp || (req_valid && !row_hit)) begin
          st_n = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
        end else if (req_valid) st_n = ST_COL;
      end
      ST_PRE: if (tmr_zero) begin
        if (pend) begin
          st_n = ST_ACT; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
        end else st_n = ST_IDLE;
      end
      ST_REF: if (!ref_req) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; pend <= 1'b0;
      hold_row <= '0; hold_col <= '0; hold_wr <= 1'b0; hold_be <= '0; hold_wd <= '0;
      open_row <= '0;
      dram_ras_n <= 1'b1; cas_n <= 2'b11; dram_we_n <= 1'b1; dram_oe_n <= 1'b1;
      dram_addr <= '0; dram_dq_out <= '0; dram_dq_oe <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; ref_gnt <= 1'b0;
    end else begin
      st       <= st_n;
      rd_valid <= 1'b0;
      ref_gnt  <= (st_n == ST_REF);
      dram_ras_n <= !(st_n inside {ST_ACT, ST_COL, ST_CAS, ST_CP, ST_OPEN});
      if (accept) begin
        hold_row <= req_addr[ROW_W+COL_W-1:COL_W];
        hold_col <= req_addr[COL_W-1:0];
        hold_wr  <= req_write;
        hold_be  <= req_be;
        hold_wd  <= req_wdata;
      end
      if (st == ST_OPEN && st_n == ST_PRE && accept) pend <= 1'b1;
      else if (st_n == ST_ACT)                        pend <= 1'b0;
      if (st_n == ST_ACT && st != ST_ACT) begin
        dram_addr <= PIN_W'(cur_row);
        open_row  <= cur_row;
      end
      if (st_n == ST_COL) begin
        dram_addr   <= PIN_W'(cur_col);
        dram_we_n   <= !cur_wr;
        dram_oe_n   <= cur_wr;
        dram_dq_out <= cur_wd;
        dram_dq_oe  <= cur_wr;
      end
      if (st_n == ST_CAS && st == ST_COL) cas_n <= ~hold_be;
      if (st_n == ST_CP && st == ST_CAS)  cas_n <= 2'b11;
      if (st == ST_CP && st_n == ST_OPEN) begin
        if (!hold_wr) begin
          rd_data  <= dram_dq_in;
          rd_valid <= 1'b1;
        end
        dram_we_n  <= 1'b1;
        dram_oe_n  <= 1'b1;
        dram_dq_oe <= 1'b0;
      end
    end
  end

  assign dram_lcas_n = cas_n[0];
  assign dram_ucas_n = cas_n[1];
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int T_RP      = 3,
  parameter int RAS_LIMIT = 12500
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rd_valid,
  input logic ref_gnt,
  input logic dram_ras_n,
  input logic dram_ucas_n,
  input logic dram_lcas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  int unsigned lo_cnt, hi_cnt;
  logic cas_hi;
  assign cas_hi = dram_lcas_n & dram_ucas_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= 0;
      hi_cnt <= T_RP;
    end else begin
      lo_cnt <= dram_ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= !dram_ras_n ? 0 : ((hi_cnt < T_RP + 8) ? hi_cnt + 1 : hi_cnt);
    end
  end

  a_r4_we_early: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_hi) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));

  a_r10_cas_in_row: assert property (@(posedge clk) disable iff (rst)
    !cas_hi |-> !dram_ras_n);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r8_grant_idle: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (dram_ras_n && cas_hi && !req_ready));

  a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= T_RP));

  a_r9_ras_limit: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (lo_cnt < RAS_LIMIT));
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.T_RP(T_RP), .RAS_LIMIT(RAS_LIMIT)) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
  .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb_top;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 2, T_RP = 3, RAS_LIMIT = 40;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, ref_req = 0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic [15:0] rd_data, dram_dq_out;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [9:0] dram_addr;

  int checks = 0, errors = 0, cyc = 0;

  edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .RAS_LIMIT(RAS_LIMIT)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n),
    .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #4 clk = ~clk;

  // DRAM model: small window of rows 0..15, columns 0..15
  logic [15:0] mem [0:255];
  logic [9:0]  cur_row = '0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  int act_cnt = 0, proto_err = 0, late_err = 0;
  int hi_run = 100, min_hi = 100, lo_run = 0, max_lo = 0;
  int ras_fall_cyc = 0, last_rcd = 0, cas_lo = 0, last_cas_w = 0;
  logic first_cas = 0;

  always @(negedge clk) begin
    logic cas_hi_now;
    cyc++;
    cas_hi_now = dram_lcas_n & dram_ucas_n;
    if (!rst) begin
      if (p_ras && !dram_ras_n) begin
        act_cnt++;
        cur_row = dram_addr;
        if (hi_run < min_hi) min_hi = hi_run;
        ras_fall_cyc = cyc; first_cas = 1;
      end
      if (!p_ras && dram_ras_n) dram_dq_in <= 16'hBAD0;
      if (dram_ras_n) begin hi_run++; lo_run = 0; end
      else begin
        hi_run = 0; lo_run++;
        if (lo_run > max_lo) max_lo = lo_run;
      end
      if (p_cas && !cas_hi_now) begin
        logic [7:0] idx;
        idx = {cur_row[3:0], dram_addr[3:0]};
        if (dram_ras_n) proto_err++;
        if (first_cas) begin last_rcd = cyc - ras_fall_cyc; first_cas = 0; end
        if (!dram_we_n) begin
          if (p_we || !dram_dq_oe || !dram_oe_n) late_err++;
          if (!dram_lcas_n) mem[idx][7:0]  = dram_dq_out[7:0];
          if (!dram_ucas_n) mem[idx][15:8] = dram_dq_out[15:8];
        end else begin
          dram_dq_in <= mem[idx];
        end
      end
      if (!cas_hi_now) cas_lo++;
      else if (!p_cas) begin last_cas_w = cas_lo; cas_lo = 0; end
    end
    p_ras = dram_ras_n; p_cas = cas_hi_now; p_we = dram_we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [19:0] a, input logic wr, input logic [1:0] be,
                       input logic [15:0] wd);
    req_valid = 1; req_addr = a; req_write = wr; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic read_word(input logic [19:0] a, output logic [15:0] d, input string req);
    int t = 0;
    issue(a, 0, 2'b11, 16'h0);
    while (!rd_valid && t < 50) begin @(negedge clk); t++; end
    check(rd_valid, req, rd_valid, 1);
    d = rd_data;
    @(negedge clk);
    check(!rd_valid, "R7 pulse width", rd_valid, 0);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n &&
          !dram_dq_oe && !rd_valid && !ref_gnt, "R1 strobes in reset",
          {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 5'h1f);
    @(negedge clk); rst = 0; @(negedge clk);
    check(req_ready && dram_ras_n && !dram_dq_oe, "R1 after reset",
          {req_ready, dram_ras_n}, 2'b11);
  endtask

  task automatic t_word_page;
    logic [15:0] d; int a0;
    a0 = act_cnt;
    issue({10'd5, 10'd3}, 1, 2'b11, 16'hA5C3);
    wait_cycles(8);
    check(mem[{4'd5, 4'd3}] == 16'hA5C3, "R2 row/col split on write",
          mem[{4'd5, 4'd3}], 16'hA5C3);
    check(late_err == 0, "R4 early write", late_err, 0);
    check(last_rcd == T_RCD + 1, "R10 row to column delay", last_rcd, T_RCD + 1);
    check(last_cas_w == T_CAS, "R10 column pulse width", last_cas_w, T_CAS);
    read_word({10'd5, 10'd3}, d, "R7 read valid");
    check(d == 16'hA5C3, "R7 read data", d, 16'hA5C3);
    check(act_cnt == a0 + 1, "R5 page hit no new row strobe", act_cnt - a0, 1);
  endtask

  task automatic t_bytes;
    logic [15:0] d;
    issue({10'd5, 10'd4}, 1, 2'b11, 16'h1111);
    issue({10'd5, 10'd4}, 1, 2'b01, 16'hAA22);
    issue({10'd5, 10'd4}, 1, 2'b10, 16'h33BB);
    read_word({10'd5, 10'd4}, d, "R3 read valid");
    check(d == 16'h3322, "R3 byte lanes", d, 16'h3322);
    check(late_err == 0, "R4 byte writes early", late_err, 0);
  endtask

  task automatic t_row_miss;
    logic [15:0] d; int a0;
    a0 = act_cnt;
    issue({10'd7, 10'd9}, 1, 2'b11, 16'h0F0F);
    read_word({10'd5, 10'd3}, d, "R6 read valid");
    check(d == 16'hA5C3, "R2 read from other row", d, 16'hA5C3);
    check(act_cnt == a0 + 2, "R6 row change activates", act_cnt - a0, 2);
    check(min_hi >= T_RP, "R6 precharge length", min_hi, T_RP);
    check(mem[{4'd7, 4'd9}] == 16'h0F0F, "R2 second row written",
          mem[{4'd7, 4'd9}], 16'h0F0F);
  endtask

  task automatic t_refresh;
    int t = 0, a0;
    issue({10'd7, 10'd1}, 1, 2'b11, 16'h5555);
    wait_cycles(6);
    check(!dram_ras_n, "R8 row open before refresh", dram_ras_n, 0);
    ref_req = 1;
    while (!ref_gnt && t < 40) begin @(negedge clk); t++; end
    check(ref_gnt && dram_ras_n && dram_lcas_n && dram_ucas_n && !req_ready,
          "R8 grant with row closed", {ref_gnt, dram_ras_n, req_ready}, 3'b110);
    ref_req = 0;
    wait_cycles(2);
    check(!ref_gnt, "R8 grant released", ref_gnt, 0);
    a0 = act_cnt;
    issue({10'd7, 10'd2}, 1, 2'b11, 16'h6666);
    wait_cycles(6);
    check(act_cnt == a0 + 1, "R8 page closed by refresh", act_cnt - a0, 1);
  endtask

  task automatic t_ras_limit;
    issue({10'd2, 10'd2}, 1, 2'b11, 16'h2222);
    wait_cycles(RAS_LIMIT + 20);
    check(dram_ras_n, "R9 idle row closed", dram_ras_n, 1);
    check(max_lo <= RAS_LIMIT, "R9 row low run", max_lo, RAS_LIMIT);
    check(proto_err == 0, "R10 column strobe only in row", proto_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    wait_cycles(3);
    t_reset;
    t_word_page;
    t_bytes;
    t_row_miss;
    t_refresh;
    t_ras_limit;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(20000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule